// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block predicts whether a branch will be taken and where it will jump. A fetch stage presents a 32-bit branch instruction address on the lookup port. One cycle later the block returns three things: whether it holds an entry for that branch, a taken or not-taken prediction, and the stored destination address. When the branch resolves later in the pipeline, the execute stage reports the same address on the update port, together with the real outcome and the real destination. The block then either trains an existing entry or creates a new one.

Storage is four ways by 256 sets, which gives 1024 lines. Each line holds a valid flag, a 24-bit tag, a 32-bit destination and a 2-bit saturating confidence counter. A branch gets a line only the first time it is seen taken, and that line starts at the strongest taken value. A branch with no line is always predicted not taken. When a set is full, the least recently trained or allocated way is replaced.

Top module: `branch_target_buffer`

## Requirements
- R1: The set index is address bits [7:0] and the tag is bits [31:8]. The tag is compared against all four ways of the indexed set. The lookup result is registered and appears on the first rising edge after the address is applied.
- R2: After synchronous reset every line is invalid, so every lookup misses.
- R3: A lookup that misses reports lkHit=0, lkPredTaken=0 and lkTarget=0.
- R4: A lookup that hits reports lkPredTaken=1 when the line's counter is 2 or 3, and 0 when it is 0 or 1. lkTarget is the stored destination.
- R5: A taken update that misses allocates a line. A not-taken update that misses changes nothing, and a later lookup of that address still misses.
- R6: A newly allocated line stores the update's tag and destination, and its counter is set to 3.
- R7: A taken update that hits increments the counter, saturating at 3, and overwrites the stored destination with updTarget.
- R8: A not-taken update that hits decrements the counter, saturating at 0, and leaves the stored destination unchanged.
- R9: Allocation takes the lowest-numbered invalid way of the set. If no way is invalid, it takes the least recently used way, where use means an update that hit or an allocation. Lookups do not count as use.
- R10: A lookup and an update in the same cycle are independent. The lookup sees the contents as they were before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lkAddr | input | 32 | Branch address to look up |
| lkHit | output | 1 | Registered: a line matched lkAddr |
| lkPredTaken | output | 1 | Registered: predicted taken |
| lkTarget | output | 32 | Registered: predicted destination, zero on miss |
| updValid | input | 1 | A resolved branch is being reported this cycle |
| updAddr | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 for taken |
| updTarget | input | 32 | Resolved destination address |

## Verification
The assertions assume that updAddr, updTaken and updTarget carry meaningful values only while updValid is high. They also assume that a taken branch reported in one cycle is not evicted by an update in the very next cycle, so the property that checks a hit after a taken update requires the following cycle to be free of updates. The bench applies every update as a single-cycle updValid pulse with a quiet cycle after it. It holds lkAddr steady across the edge that registers the result. It overlaps a lookup with an update only in the one directed case that targets R10.

// File: rtl/btb_pkg.sv
package btb_pkg;
  // Way count is a shared configuration: 2**WAY_W ways per set.
  parameter int WAY_W = 2;
  localparam int WAYS = 1 << WAY_W;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_MAX = '1;

  // Strobes from control to datapath for one update cycle.
  typedef struct packed {
    logic             alloc;       // create a new line in way
    logic             train;       // rewrite counter of a matching line
    logic             loadTarget;  // store updTarget into way
    logic [WAY_W-1:0] way;
    logic [CTR_W-1:0] ctr;         // counter value to write
  } strobe_t;
endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             lkAddr,
  input  logic [ADDR_W-1:0]             updAddr,
  input  logic [ADDR_W-1:0]             updTarget,
  input  strobe_t                       strb,
  output logic [$clog2(SETS)-1:0]       updSet,
  output logic [WAYS-1:0]               updMatch,
  output logic [WAYS-1:0]               updValidVec,
  output logic [WAYS-1:0][CTR_W-1:0]    updCtrs,
  output logic                          lkHit,
  output logic                          lkPred,
  output logic [ADDR_W-1:0]             lkTarget
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic               validQ [SETS][WAYS];
  logic [TAG_W-1:0]   tagQ   [SETS][WAYS];
  logic [ADDR_W-1:0]  tgtQ   [SETS][WAYS];
  logic [CTR_W-1:0]   ctrQ   [SETS][WAYS];

  logic [IDX_W-1:0] lkIdx;
  logic [TAG_W-1:0] lkTag, updTag;
  logic [WAYS-1:0]  lkMatch;

  assign lkIdx  = lkAddr[IDX_W-1:0];
  assign lkTag  = lkAddr[ADDR_W-1:IDX_W];
  assign updSet = updAddr[IDX_W-1:0];
  assign updTag = updAddr[ADDR_W-1:IDX_W];

  for (genvar g = 0; g < WAYS; g++) begin : gWay
    assign lkMatch[g]     = validQ[lkIdx][g] && (tagQ[lkIdx][g] == lkTag);
    assign updMatch[g]    = validQ[updSet][g] && (tagQ[updSet][g] == updTag);
    assign updValidVec[g] = validQ[updSet][g];
    assign updCtrs[g]     = ctrQ[updSet][g];
  end

  logic              lkHitC;
  logic [CTR_W-1:0]  lkCtrSel;
  logic [ADDR_W-1:0] lkTgtSel;

  always_comb begin
    lkHitC   = 1'b0;
    lkCtrSel = '0;
    lkTgtSel = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (lkMatch[w]) begin
        lkHitC   = 1'b1;
        lkCtrSel = lkCtrSel | ctrQ[lkIdx][w];
        lkTgtSel = lkTgtSel | tgtQ[lkIdx][w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lkHit    <= 1'b0;
      lkPred   <= 1'b0;
      lkTarget <= '0;
    end else begin
      lkHit    <= lkHitC;
      lkPred   <= lkHitC && lkCtrSel[CTR_W-1];
      lkTarget <= lkTgtSel;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          validQ[s][w] <= 1'b0;
    end else if (strb.alloc) begin
      validQ[updSet][strb.way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.alloc) tagQ[updSet][strb.way] <= updTag;
    if (strb.alloc || strb.train) ctrQ[updSet][strb.way] <= strb.ctr;
    if (strb.loadTarget) tgtQ[updSet][strb.way] <= updTarget;
  end
endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
#(
  parameter int SETS = 256
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        updValid,
  input  logic                        updTaken,
  input  logic [$clog2(SETS)-1:0]     updSet,
  input  logic [WAYS-1:0]             updMatch,
  input  logic [WAYS-1:0]             updValidVec,
  input  logic [WAYS-1:0][CTR_W-1:0]  updCtrs,
  output strobe_t                     strb
);
  logic [WAY_W-1:0] ageQ [SETS][WAYS];

  logic             hitAny;
  logic [WAY_W-1:0] hitWay, victim;
  logic             haveFree;
  logic [CTR_W-1:0] curCtr;

  always_comb begin
    hitAny = |updMatch;
    hitWay = '0;
    for (int w = 0; w < WAYS; w++)
      if (updMatch[w]) hitWay = WAY_W'(w);
    haveFree = 1'b0;
    victim   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!updValidVec[w]) begin
        haveFree = 1'b1;
        victim   = WAY_W'(w);
      end
    end
    if (!haveFree) begin
      for (int w = 0; w < WAYS; w++)
        if (ageQ[updSet][w] == WAY_W'(WAYS - 1)) victim = WAY_W'(w);
    end
    curCtr = updCtrs[hitWay];
  end

  always_comb begin
    strb = '0;
    if (updValid) begin
      if (hitAny) begin
        strb.train      = 1'b1;
        strb.way        = hitWay;
        strb.loadTarget = updTaken;
        if (updTaken) strb.ctr = (curCtr == CTR_MAX) ? curCtr : curCtr + 1'b1;
        else          strb.ctr = (curCtr == '0) ? curCtr : curCtr - 1'b1;
      end else if (updTaken) begin
        strb.alloc      = 1'b1;
        strb.way        = victim;
        strb.loadTarget = 1'b1;
        strb.ctr        = CTR_MAX;
      end
    end
  end

  // Age 0 is most recent, WAYS-1 the replacement candidate.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ageQ[s][w] <= WAY_W'(w);
    end else if (strb.alloc || strb.train) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == strb.way)
          ageQ[updSet][w] <= '0;
        else if (ageQ[updSet][w] < ageQ[updSet][strb.way])
          ageQ[updSet][w] <= ageQ[updSet][w] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lkAddr,
  output logic              lkHit,
  output logic              lkPredTaken,
  output logic [ADDR_W-1:0] lkTarget,
  input  logic              updValid,
  input  logic [ADDR_W-1:0] updAddr,
  input  logic              updTaken,
  input  logic [ADDR_W-1:0] updTarget
);
  localparam int IDX_W = $clog2(SETS);

  strobe_t                  strb;
  logic [IDX_W-1:0]         updSet;
  logic [WAYS-1:0]          updMatch, updValidVec;
  logic [WAYS-1:0][CTR_W-1:0] updCtrs;

  btb_datapath #(.ADDR_W(ADDR_W), .SETS(SETS)) uDp (
    .clk(clk), .rst(rst), .lkAddr(lkAddr), .updAddr(updAddr),
    .updTarget(updTarget), .strb(strb), .updSet(updSet),
    .updMatch(updMatch), .updValidVec(updValidVec), .updCtrs(updCtrs),
    .lkHit(lkHit), .lkPred(lkPredTaken), .lkTarget(lkTarget)
  );

  btb_control #(.SETS(SETS)) uCtl (
    .clk(clk), .rst(rst), .updValid(updValid), .updTaken(updTaken),
    .updSet(updSet), .updMatch(updMatch), .updValidVec(updValidVec),
    .updCtrs(updCtrs), .strb(strb)
  );
endmodule

// File: rtl/btb_checker.sv
module btb_checker
  import btb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic              lkPredTaken,
  input logic [ADDR_W-1:0] lkTarget,
  input logic              updValid,
  input logic [ADDR_W-1:0] updAddr,
  input logic              updTaken,
  input logic [ADDR_W-1:0] updTarget,
  input strobe_t           strb
);
  a_r2_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lkHit);

  a_r3_miss_not_taken: assert property (@(posedge clk) disable iff (rst)
    !lkHit |-> (!lkPredTaken && lkTarget == '0));

  a_r5_alloc_only_taken: assert property (@(posedge clk) disable iff (rst)
    strb.alloc |-> (updValid && updTaken));

  a_r6_alloc_strong: assert property (@(posedge clk) disable iff (rst)
    strb.alloc |-> (strb.ctr == CTR_MAX && strb.loadTarget));

  a_r6_taken_then_hit: assert property (@(posedge clk) disable iff (rst)
    (updValid && updTaken) ##1 (!updValid && lkAddr == $past(updAddr))
    |=> (lkHit && lkTarget == $past(updTarget, 2)));

  a_r8_not_taken_keeps_target: assert property (@(posedge clk) disable iff (rst)
    (strb.train && !updTaken) |-> !strb.loadTarget);

  a_r9_single_action: assert property (@(posedge clk) disable iff (rst)
    !(strb.alloc && strb.train));
endmodule

bind branch_target_buffer btb_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rst(rst), .lkAddr(lkAddr), .lkHit(lkHit),
  .lkPredTaken(lkPredTaken), .lkTarget(lkTarget), .updValid(updValid),
  .updAddr(updAddr), .updTaken(updTaken), .updTarget(updTarget), .strb(strb)
);

// File: tb/tb_branch_target_buffer.sv
module tb_branch_target_buffer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lkAddr = '0;
  logic        lkHit, lkPredTaken;
  logic [31:0] lkTarget;
  logic        updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  branch_target_buffer dut (
    .clk(clk), .rst(rst), .lkAddr(lkAddr), .lkHit(lkHit),
    .lkPredTaken(lkPredTaken), .lkTarget(lkTarget), .updValid(updValid),
    .updAddr(updAddr), .updTaken(updTaken), .updTarget(updTarget)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk);
    lkAddr = a;
    @(negedge clk);
  endtask

  task automatic update(input logic [31:0] a, input logic t, input logic [31:0] tg);
    @(negedge clk);
    updValid = 1'b1; updAddr = a; updTaken = t; updTarget = tg;
    @(negedge clk);
    updValid = 1'b0;
  endtask

  task automatic expectLookup(input string req, input logic [31:0] a,
                              input logic h, input logic p, input logic [31:0] tg);
    lookup(a);
    chk({req, " hit"}, 32'(lkHit), 32'(h));
    chk({req, " pred"}, 32'(lkPredTaken), 32'(p));
    chk({req, " target"}, lkTarget, tg);
  endtask

  // Sequence with shared set 0x02 and a neighbour in set 0x04.
  function automatic logic [31:0] seqAddr(input int i);
    case (i)
      0, 3, 5, 8, 9: return 32'h0024_6802;
      1, 7:          return 32'h0024_6804;
      2, 6:          return 32'h0024_4202;
      default:       return 32'h0024_0202;
    endcase
  endfunction

  function automatic logic seqTaken(input int i);
    return !(i == 3 || i == 5 || i == 8);
  endfunction

  function automatic logic [31:0] evAddr(input int setNo, input int k);
    return {24'h000100 + 24'(k), 8'(setNo)};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R2, R3: empty after reset
    expectLookup("R2 R3 reset", 32'h0024_6802, 1'b0, 1'b0, 32'h0);
    expectLookup("R2 R3 reset", 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0);

    // R4 R6 R7 R8: mixed sequence; model counters arithmetically
    begin
      logic [31:0] mAddr [4];
      int          mCtr  [4];
      bit          mVal  [4];
      int          n = 0;
      for (int i = 0; i < 10; i++) begin
        logic [31:0] a = seqAddr(i);
        int slot = -1;
        for (int k = 0; k < n; k++) if (mVal[k] && mAddr[k] == a) slot = k;
        if (slot < 0) expectLookup("R3 seq miss", a, 1'b0, 1'b0, 32'h0);
        else expectLookup("R4 seq hit", a, 1'b1, mCtr[slot] >= 2, a + 32'h100);
        update(a, seqTaken(i), a + 32'h100);
        if (slot < 0 && seqTaken(i)) begin
          mAddr[n] = a; mCtr[n] = 3; mVal[n] = 1'b1; n++;
        end else if (slot >= 0) begin
          if (seqTaken(i)) mCtr[slot] = (mCtr[slot] == 3) ? 3 : mCtr[slot] + 1;
          else             mCtr[slot] = (mCtr[slot] == 0) ? 0 : mCtr[slot] - 1;
        end
      end
    end

    // R5: not-taken miss allocates nothing
    update(32'h7777_7777, 1'b0, 32'h1234_0000);
    expectLookup("R5 no alloc", 32'h7777_7777, 1'b0, 1'b0, 32'h0);

    // R6 R7 R8 R4: counter walk with pseudo-random outcomes
    begin
      logic [31:0] a = 32'h1234_5633;
      logic [31:0] tg = 32'hC000_0000;
      int ctr = 3;
      logic [7:0] lfsr = 8'hA7;
      update(a, 1'b1, tg);
      expectLookup("R6 new strong", a, 1'b1, 1'b1, tg);
      for (int i = 0; i < 40; i++) begin
        logic t = lfsr[0];
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        update(a, t, 32'hC000_0000 + 32'(i));
        if (t) begin
          ctr = (ctr == 3) ? 3 : ctr + 1;
          tg = 32'hC000_0000 + 32'(i);
          expectLookup("R7 taken hit", a, 1'b1, ctr >= 2, tg);
        end else begin
          ctr = (ctr == 0) ? 0 : ctr - 1;
          expectLookup("R8 not-taken hit", a, 1'b1, ctr >= 2, tg);
        end
      end
      // Saturation at both ends
      for (int i = 0; i < 4; i++) update(a, 1'b0, 32'h0);
      expectLookup("R8 floor", a, 1'b1, 1'b0, tg);
      update(a, 1'b1, 32'hD000_0000);
      expectLookup("R8 floor+1", a, 1'b1, 1'b0, 32'hD000_0000);
      update(a, 1'b1, 32'hD000_0000);
      expectLookup("R4 weak taken", a, 1'b1, 1'b1, 32'hD000_0000);
      for (int i = 0; i < 4; i++) update(a, 1'b1, 32'hD000_0000);
      update(a, 1'b0, 32'h0);
      expectLookup("R7 ceiling", a, 1'b1, 1'b1, 32'hD000_0000);
    end

    // R9: invalid ways fill first, then LRU victim for each way position
    for (int v = 0; v < 4; v++) begin
      int s = 8'h80 + v;
      for (int k = 0; k < 4; k++) update(evAddr(s, k), 1'b1, 32'(k + 1));
      for (int k = 0; k < 4; k++)
        expectLookup("R9 fill invalid", evAddr(s, k), 1'b1, 1'b1, 32'(k + 1));
      update(evAddr(s, v), 1'b1, 32'(v + 1));
      for (int k = 0; k < 4; k++)
        if (k != v) update(evAddr(s, k), 1'b1, 32'(k + 1));
      update(evAddr(s, 4), 1'b1, 32'h55);
      for (int k = 0; k < 5; k++) begin
        if (k == v) expectLookup("R9 LRU evicted", evAddr(s, k), 1'b0, 1'b0, 32'h0);
        else if (k == 4) expectLookup("R9 new line", evAddr(s, k), 1'b1, 1'b1, 32'h55);
        else expectLookup("R9 kept", evAddr(s, k), 1'b1, 1'b1, 32'(k + 1));
      end
    end

    // R10: lookup overlapping an allocating update sees old state
    @(negedge clk);
    lkAddr = 32'h0BAD_F00D;
    updValid = 1'b1; updAddr = 32'h0BAD_F00D; updTaken = 1'b1; updTarget = 32'hFEED;
    @(negedge clk);
    updValid = 1'b0;
    chk("R10 same-cycle old state", 32'(lkHit), 32'h0);
    @(negedge clk);
    chk("R10 next cycle hit", 32'(lkHit), 32'h1);
    chk("R10 next cycle target", lkTarget, 32'hFEED);

    // R1: one line per set across every index, distinct tags
    for (int i = 0; i < 256; i++)
      update({24'(i * 7 + 1), 8'(i)}, 1'b1, 32'(i) * 32'h0101_0101 ^ 32'h5);
    for (int i = 0; i < 256; i++) begin
      expectLookup("R1 index sweep", {24'(i * 7 + 1), 8'(i)}, 1'b1, 1'b1,
                   32'(i) * 32'h0101_0101 ^ 32'h5);
      lookup({24'hEEEEEE, 8'(i)});
      chk("R1 tag mismatch", 32'(lkHit), 32'h0);
    end

    // R1: result registered, not visible before the edge
    @(negedge clk);
    lkAddr = {24'(3 * 7 + 1), 8'd3};
    #1;
    chk("R1 registered latency", 32'(lkHit), 32'h0);
    @(negedge clk);
    chk("R1 after one edge", 32'(lkHit), 32'h1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule